// File: doc/BRIEF.md
# Random-Access Scan Register Array

This block is a bank of state flip-flops that serve the surrounding logic as ordinary registers, but that test equipment can also reach one cell at a time, the way it would reach a word in a memory. A short address register is loaded one bit per address clock enable and decoded into a one-hot select. Test control then picks the mode. In normal mode every cell takes its functional input on the main clock enable. In scan mode only the selected cell is written, from the single scan-in pin, and all other cells hold. Scan-out always shows the selected cell's value.

Because the selected cell changes alone, a test can flip one state bit and leave the rest in place. This suits single-input-change delay tests and avoids shifting a whole chain to change a single value. The address path and the array have separate enables, so loading an address never disturbs the stored state.

Top module: `ras_array`

## Requirements
- R1: While rstN is low, and on its release, all cells are 0 and the address register is 0, so cell 0 is selected.
- R2: The address register is ADDR_W = clog2(NUM_CELLS) bits wide. On each cycle with addrClkEn high it shifts left by one and addrIn enters bit 0, so the address is loaded MSB first over ADDR_W cycles.
- R3: With clkEn high and testMode low (normal mode), every cell loads its own bit of funcD on that clock edge.
- R4: With clkEn high and testMode high (scan mode), the cell whose index equals the address loads scanIn.
- R5: In scan mode every cell other than the addressed one keeps its value, so a scan write changes at most one bit of funcQ.
- R6: scanOut is a combinational copy of the funcQ bit at the current address.
- R7: An address of NUM_CELLS or more selects no cell: a scan write changes no cell and scanOut is 0.
- R8: addrClkEn does not affect the cells, and clkEn does not affect the address register.
- R9: With clkEn low, no cell changes, whatever testMode, funcD and scanIn are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | Enable for the cell array |
| addrClkEn | input | 1 | Enable for the address shift register |
| testMode | input | 1 | 1 selects scan mode, 0 selects normal mode |
| addrIn | input | 1 | Serial address input, MSB first |
| scanIn | input | 1 | Scan data written into the selected cell |
| funcD | input | NUM_CELLS | Functional next-state inputs, one per cell |
| funcQ | output | NUM_CELLS | Cell outputs |
| scanOut | output | 1 | Value of the selected cell, or 0 when out of range |

## Verification
The bench builds the array with 12 cells. This gives a 4-bit address whose codes 12 to 15 are out of range, so the no-select path for writes and for scan-out can be exercised alongside valid cells. Because 12 is not a power of two, a decoder that wraps or truncates the address would be caught. Random cycles that mix the two enables and both modes also test whether the address path and the array disturb each other.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef struct packed {
    logic captureAll;
    logic scanWrite;
    logic addrShift;
  } rasStrobeT;
endpackage

// File: rtl/ras_addr_dec.sv
module ras_addr_dec #(
  parameter int NUM_CELLS = 12,
  parameter int ADDR_W    = 4
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_CELLS-1:0] sel
);
  for (genvar i = 0; i < NUM_CELLS; i++) begin : gDec
    assign sel[i] = (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int NUM_CELLS = 12,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkEn,
  input  logic                 addrClkEn,
  input  logic                 testMode,
  input  logic                 addrIn,
  output rasStrobeT            strobe,
  output logic [NUM_CELLS-1:0] cellSel
);
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W:0]   shiftVec;

  assign shiftVec = {addrReg, addrIn};

  always_ff @(posedge clk) begin
    if (!rstN)          addrReg <= '0;
    else if (addrClkEn) addrReg <= shiftVec[ADDR_W-1:0];
  end

  always_comb begin
    strobe.captureAll = clkEn && !testMode;
    strobe.scanWrite  = clkEn && testMode;
    strobe.addrShift  = addrClkEn;
  end

  ras_addr_dec #(.NUM_CELLS(NUM_CELLS), .ADDR_W(ADDR_W)) u_dec (
    .addr(addrReg),
    .sel (cellSel)
  );

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !addrClkEn |=> $stable(addrReg)); // R8
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cellSel)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.captureAll && strobe.scanWrite)); // R3
endmodule

// File: rtl/ras_cells.sv
module ras_cells
  import ras_pkg::*;
#(
  parameter int NUM_CELLS = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rasStrobeT            strobe,
  input  logic [NUM_CELLS-1:0] cellSel,
  input  logic [NUM_CELLS-1:0] funcD,
  input  logic                 scanIn,
  output logic [NUM_CELLS-1:0] cellQ,
  output logic                 scanOut
);
  for (genvar i = 0; i < NUM_CELLS; i++) begin : gCell
    always_ff @(posedge clk) begin
      if (!rstN)                                cellQ[i] <= 1'b0;
      else if (strobe.captureAll)               cellQ[i] <= funcD[i];
      else if (strobe.scanWrite && cellSel[i])  cellQ[i] <= scanIn;
    end
  end

  assign scanOut = |(cellSel & cellQ);

  AST_NORMAL_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureAll |=> (cellQ == $past(funcD))); // R3
  AST_SCAN_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.scanWrite |=> ($countones(cellQ ^ $past(cellQ)) <= 1)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.captureAll || strobe.scanWrite) |=> $stable(cellQ)); // R9
  AST_NOSEL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cellSel == '0) |-> !scanOut); // R7
endmodule

// File: rtl/ras_array.sv
module ras_array
  import ras_pkg::*;
#(
  parameter int NUM_CELLS = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkEn,
  input  logic                 addrClkEn,
  input  logic                 testMode,
  input  logic                 addrIn,
  input  logic                 scanIn,
  input  logic [NUM_CELLS-1:0] funcD,
  output logic [NUM_CELLS-1:0] funcQ,
  output logic                 scanOut
);
  localparam int ADDR_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1;

  rasStrobeT            strobe;
  logic [NUM_CELLS-1:0] cellSel;

  ras_ctrl #(.NUM_CELLS(NUM_CELLS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .addrClkEn(addrClkEn),
    .testMode(testMode), .addrIn(addrIn), .strobe(strobe), .cellSel(cellSel)
  );

  ras_cells #(.NUM_CELLS(NUM_CELLS)) u_cells (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cellSel(cellSel),
    .funcD(funcD), .scanIn(scanIn), .cellQ(funcQ), .scanOut(scanOut)
  );
endmodule

// File: tb/sim_ras_array.sv
`timescale 1ns/1ps
module sim_ras_array;
  localparam int N = 12;
  localparam int W = 4;

  logic clk = 0, rstN = 0, clkEn = 0, addrClkEn = 0, testMode = 0, addrIn = 0, scanIn = 0;
  logic [N-1:0] funcD = '0;
  logic [N-1:0] funcQ;
  logic scanOut;

  logic [N-1:0] expCells = '0;
  logic [W-1:0] expAddr = '0;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ras_array #(.NUM_CELLS(N)) u0 (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .addrClkEn(addrClkEn), .testMode(testMode),
    .addrIn(addrIn), .scanIn(scanIn), .funcD(funcD), .funcQ(funcQ), .scanOut(scanOut)
  );

  function automatic logic expScan(logic [N-1:0] c, logic [W-1:0] a);
    return (int'(a) < N) ? c[a] : 1'b0;
  endfunction

  task automatic checkAll(string tag);
    nChecks++;
    if (funcQ !== expCells) begin
      nFails++;
      $display("FAIL %s funcQ actual=%h expected=%h", tag, funcQ, expCells);
    end
    nChecks++;
    if (scanOut !== expScan(expCells, expAddr)) begin
      nFails++;
      $display("FAIL %s scanOut actual=%b expected=%b (addr %0d)", tag, scanOut,
               expScan(expCells, expAddr), expAddr);
    end
  endtask

  task automatic cyc(logic [N-1:0] d, logic si, logic ai, logic tm, logic ce, logic ace, string tag);
    @(negedge clk);
    funcD = d; scanIn = si; addrIn = ai; testMode = tm; clkEn = ce; addrClkEn = ace;
    @(posedge clk);
    if (ce) begin
      if (!tm) expCells = d;
      else if (int'(expAddr) < N) expCells[expAddr] = si;
    end
    if (ace) expAddr = {expAddr[W-2:0], ai};
    #1;
    checkAll(tag);
  endtask

  task automatic loadAddr(logic [W-1:0] a, string tag);
    for (int k = W - 1; k >= 0; k--)
      cyc(N'($urandom), 1'($urandom), a[k], 1'($urandom), 1'b0, 1'b1, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    // R1: reset state
    repeat (3) @(posedge clk);
    #1; checkAll("R1 in reset");
    @(negedge clk); rstN = 1;
    @(posedge clk); #1; checkAll("R1 after release");

    // R3: normal capture
    cyc(12'hA5C, 0, 0, 0, 1, 0, "R3 capture");
    cyc(12'h3F1, 0, 0, 0, 1, 0, "R3 capture 2");
    // R2/R6: load address 5 MSB first, scanOut follows cell 5
    loadAddr(4'd5, "R2 addr shift");
    nChecks++;
    if (scanOut !== expCells[5]) begin
      nFails++; $display("FAIL R6 scanOut actual=%b expected=%b", scanOut, expCells[5]);
    end
    // R4/R5: scan write cell 5 both values
    cyc(12'hFFF, ~expCells[5], 0, 1, 1, 0, "R4 scan write");
    cyc(12'h000, ~expCells[5], 0, 1, 1, 0, "R5 others hold");
    // R8: address shift with array enable low
    loadAddr(4'd11, "R8 addr no disturb");
    cyc(12'h000, 1, 0, 1, 1, 0, "R4 top cell");
    // R7: out of range
    loadAddr(4'd13, "R7 load oor");
    cyc(12'hFFF, 1, 0, 1, 1, 0, "R7 oor write");
    cyc(12'hFFF, 0, 0, 1, 1, 0, "R7 oor write 0");
    loadAddr(4'd15, "R7 load max");
    cyc(12'h000, 1, 0, 1, 1, 0, "R7 max addr");
    // R9: clkEn low holds
    cyc(12'h000, 1, 0, 0, 0, 0, "R9 normal disabled");
    cyc(12'hFFF, 0, 0, 1, 0, 0, "R9 scan disabled");
    // R8: array update while address clock is off
    loadAddr(4'd0, "R2 addr zero");
    cyc(12'h0F0, 1, 1, 0, 1, 0, "R8 addr hold");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic tm, ce, ace;
      tm = 1'($urandom); ce = 1'($urandom); ace = (($urandom % 3) == 0);
      cyc(N'($urandom), 1'($urandom), 1'($urandom), tm, ce, ace,
          !ce ? "R9 random" : (tm ? "R5 random scan" : "R3 random normal"));
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule